// File: doc/BRIEF.md
# Serial Majority Vote Counter

This block decides whether at least `THRESH` of `N_IN` single-bit votes are high, using one shift register and one small counter instead of a wide adder tree. The vote vector is captured in parallel into a chain of shift stages, padded with zeros up to the chain length. The chain then moves one bit per clock into a ones counter. A frame controller runs a fixed frame of `STAGE_W*N_STAGES` clocks, which is 32 with the defaults. At the last slot of each frame it registers the decision, raises a one-clock strobe and captures a fresh vote vector in the same cycle.

The frame controller is a three-state machine:
- `ST_PRIME` is entered from reset. It performs the first capture and always moves to `ST_SHIFT`.
- `ST_SHIFT` shifts and counts. It stays in place until the frame counter reaches `FRAME-2`, then takes the transition to `ST_WRAP`.
- `ST_WRAP` counts the final (padding) slot, latches the decision, pulses the strobe and recaptures the votes. It always returns to `ST_SHIFT`.

When the threshold is a power of two and fewer than twice the threshold votes exist, the decision is a single bit of the next count value. Any other threshold uses a magnitude compare. The result is held steady for a whole frame. An input change therefore reaches the output between one and two frames later.

Top module: `majority_serial`

## Requirements
- R1: While reset is high, and after a mid-frame reset, `maj_o` and `done_o` are 0 on the clock following reset.
- R2: The vote vector is captured on the first rising edge with reset low, and again every 32 clocks after that (defaults).
- R3: After each frame, `maj_o` equals 1 exactly when the number of ones in the captured vector is at least 16, where bit i of `vote_i` is vote i.
- R4: `done_o` is high for exactly one clock. In steady state, consecutive strobes are 32 clocks apart.
- R5: `maj_o` changes only in the cycle in which `done_o` is high, and holds for the rest of the frame.
- R6: Changes to `vote_i` between two capture edges have no effect on the next result.
- R7: The decision boundary is exact. 15 ones give 0 and 16 ones give 1, whatever bit positions hold the ones.
- R8: The first strobe after reset appears 33 clocks after reset release, carrying the result for the vector present at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| vote_i | input | N_IN | Vote bits, sampled at each frame capture |
| maj_o | output | 1 | Held decision: count of ones reached the threshold |
| done_o | output | 1 | One-clock strobe when `maj_o` is updated |

## Verification
The bench goes after the threshold edge with 15- and 16-ones patterns placed at the low end, at the high end and interleaved. A design that counted the padding slot or dropped the last shifted bit would flip one of these decisions. It changes the votes one clock after a capture. A design that sampled late or kept sampling would then report the changed vector. It also measures the strobe spacing, including the longer first gap after reset and after a mid-frame reset. An off-by-one frame counter or a missed reload would move a strobe, widen it, or leave stale results in the scoreboard.

// File: rtl/mj_pkg.sv
package mj_pkg;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WRAP  = 2'd2
    } mj_state_e;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/mj_shift_chain.sv
module mj_shift_chain #(
    parameter int STAGE_W  = 8,
    parameter int N_STAGES = 4,
    localparam int LEN     = STAGE_W * N_STAGES
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           shift,
    input  logic [LEN-1:0] load_vec,
    output logic           ser_o
);

    logic [STAGE_W-1:0] stg [N_STAGES];

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        logic feed;
        if (s == N_STAGES - 1) begin : g_tail
            assign feed = 1'b0;
        end else begin : g_link
            assign feed = stg[s+1][STAGE_W-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else if (load) begin
                stg[s] <= load_vec[LEN-1-s*STAGE_W -: STAGE_W];
            end else if (shift) begin
                stg[s] <= {stg[s][STAGE_W-2:0], feed};
            end
        end
    end

    assign ser_o = stg[0][STAGE_W-1];

endmodule

// File: rtl/mj_ones_counter.sv
module mj_ones_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);

    assign cnt_next = cnt_q + CNT_W'(bit_i);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/mj_frame_ctrl.sv
module mj_frame_ctrl
    import mj_pkg::*;
#(
    parameter int FRAME = 32,
    localparam int FC_W = $clog2(FRAME)
) (
    input  logic clk,
    input  logic rst,
    output logic load,
    output logic shift,
    output logic count,
    output logic latch
);

    mj_state_e        state_q, state_d;
    logic [FC_W-1:0]  fcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_SHIFT;
            ST_SHIFT: if (fcnt_q == FC_W'(FRAME - 2)) state_d = ST_WRAP;
            ST_WRAP:  state_d = ST_SHIFT;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        count = 1'b0;
        latch = 1'b0;
        unique case (state_q)
            ST_PRIME: load = 1'b1;
            ST_SHIFT: begin
                shift = 1'b1;
                count = 1'b1;
            end
            ST_WRAP: begin
                count = 1'b1;
                latch = 1'b1;
                load  = 1'b1;
            end
            default: load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            fcnt_q <= '0;
        end else if (shift) begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/majority_serial.sv
module majority_serial
    import mj_pkg::*;
#(
    parameter int N_IN     = 31,
    parameter int THRESH   = 16,
    parameter int STAGE_W  = 8,
    parameter int N_STAGES = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [N_IN-1:0] vote_i,
    output logic            maj_o,
    output logic            done_o
);

    localparam int FRAME   = STAGE_W * N_STAGES;
    localparam int PAD     = FRAME - N_IN;
    localparam int CNT_W   = $clog2(FRAME + 1);
    localparam bit BIT_DEC = is_pow2(THRESH) && (N_IN < 2 * THRESH);

    logic             load, shift, count, latch;
    logic             ser;
    logic [FRAME-1:0] load_vec;
    logic [CNT_W-1:0] ones_q, ones_next;
    logic             decide;
    logic             maj_q, done_q;

    assign load_vec = {vote_i, {PAD{1'b0}}};

    mj_frame_ctrl #(.FRAME(FRAME)) u_ctrl (
        .clk   (clk_i),
        .rst   (rst_i),
        .load  (load),
        .shift (shift),
        .count (count),
        .latch (latch)
    );

    mj_shift_chain #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_chain (
        .clk      (clk_i),
        .rst      (rst_i),
        .load     (load),
        .shift    (shift),
        .load_vec (load_vec),
        .ser_o    (ser)
    );

    mj_ones_counter #(.CNT_W(CNT_W)) u_ones (
        .clk      (clk_i),
        .rst      (rst_i),
        .clr      (load),
        .en       (count),
        .bit_i    (ser),
        .cnt_q    (ones_q),
        .cnt_next (ones_next)
    );

    if (BIT_DEC) begin : g_bit_decide
        assign decide = ones_next[$clog2(THRESH)];
    end else begin : g_cmp_decide
        assign decide = (ones_next >= CNT_W'(THRESH));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            maj_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= latch;
            if (latch) maj_q <= decide;
        end
    end

    assign maj_o  = maj_q;
    assign done_o = done_q;

endmodule

// File: rtl/mj_checker.sv
module mj_checker #(
    parameter int N_IN  = 31,
    parameter int FRAME = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             maj,
    input logic             done,
    input logic [CNT_W-1:0] ones
);

    logic [CNT_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (done) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!maj && !done));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_period_r4: assert property (@(posedge clk) disable iff (rst)
        (done && seen_q) |-> (gap_q == CNT_W'(FRAME - 1)));

    p_hold_result_r5: assert property (@(posedge clk) disable iff (rst)
        !done |-> (maj == $past(maj)));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ones <= CNT_W'(N_IN));

endmodule

bind majority_serial mj_checker #(
    .N_IN  (N_IN),
    .FRAME (FRAME),
    .CNT_W (CNT_W)
) u_mj_checker (
    .clk  (clk_i),
    .rst  (rst_i),
    .maj  (maj_o),
    .done (done_o),
    .ones (ones_q)
);

// File: tb/test_majority_serial.sv
module test_majority_serial;

    localparam int N_IN   = 31;
    localparam int THRESH = 16;
    localparam int FRAME  = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_IN-1:0] vote = '0;
    logic            maj, done;

    always #4 clk = ~clk;

    majority_serial i_majority_serial (
        .clk_i  (clk),
        .rst_i  (rst),
        .vote_i (vote),
        .maj_o  (maj),
        .done_o (done)
    );

    int total = 0;
    int bad   = 0;
    bit exp_q[$];
    bit running = 0;
    bit first   = 1;
    int gap     = -1;
    bit prev_maj = 0, prev_done = 0, held_ok = 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ref_maj(input logic [N_IN-1:0] v);
        return $countones(v) >= THRESH;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver: called at a negedge; the next rising edge captures v (R2)
    task automatic drive_frame(input logic [N_IN-1:0] v,
                               input bit glitch, input logic [N_IN-1:0] alt);
        vote = v;
        exp_q.push_back(ref_maj(v));
        for (int k = 1; k <= FRAME; k++) begin
            @(negedge clk);
            if (glitch && k == 1) vote = alt;   // R6: change after capture
        end
    endtask

    task automatic arm();
        gap = -1; first = 1; prev_maj = 0; prev_done = 0; held_ok = 1;
        running = 1;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (running) begin
            gap++;
            if (done) begin
                check(!prev_done, "R4 strobe width", 2, 1);
                if (first) check(gap == FRAME + 1, "R8 first strobe gap", gap, FRAME + 1);
                else       check(gap == FRAME, "R4 strobe period", gap, FRAME);
                check(held_ok, "R5 result held through frame", 0, 1);
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected result", int'(maj), -1);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(maj == e, "R3/R7 majority decision", int'(maj), int'(e));
                end
                gap = 0; first = 0; held_ok = 1;
            end else if (maj != prev_maj) begin
                held_ok = 0;
            end
            prev_maj  = maj;
            prev_done = done;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [N_IN-1:0] lfsr;
        repeat (3) @(negedge clk);
        check(maj == 1'b0 && done == 1'b0, "R1 outputs in reset", int'({maj, done}), 0);
        rst = 1'b0;
        arm();
        drive_frame('0, 0, '0);
        drive_frame('1, 0, '0);                               // 31 ones
        drive_frame(31'h0000_FFFF, 0, '0);                    // R7 16 low
        drive_frame(31'h0000_7FFF, 0, '0);                    // R7 15 low
        drive_frame(31'h7FFF_8000, 0, '0);                    // R7 16 high
        drive_frame(31'h7FFF_0000, 0, '0);                    // R7 15 high
        drive_frame(31'h5555_5555, 0, '0);                    // R7 16 interleaved
        drive_frame(31'h2AAA_AAAA, 0, '0);                    // R7 15 interleaved
        drive_frame(31'h4000_0000, 0, '0);
        drive_frame(31'h0000_7FFF, 1, '1);                    // R6 15 then all ones
        drive_frame(31'h7FFF_8000, 1, '0);                    // R6 16 then zeros
        lfsr = 31'h1234_5679;
        for (int i = 0; i < 6; i++) begin
            lfsr = {lfsr[29:0], lfsr[30] ^ lfsr[27]};
            drive_frame(lfsr, 0, '0);
        end
        // mid-frame reset (R1)
        vote = 31'h7FFF_FFFF;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        running = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(maj == 1'b0 && done == 1'b0, "R1 outputs after mid-frame reset", int'({maj, done}), 0);
        rst = 1'b0;
        arm();
        drive_frame('1, 0, '0);
        drive_frame(31'h0000_7FFF, 0, '0);
        drive_frame(31'h0001_FFFE, 0, '0);                    // 16 ones
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results delivered", exp_q.size(), 0);
        running = 0;
        finish_run();
    end

endmodule